// File: doc/BRIEF.md
# Serial Byte Memory with Signed Position Counter

This block is a serial-bus slave for a larger chip. Behind one SPI port it holds a byte-addressed array (2,048 bytes by default), an 8-bit status register with a write-enable latch, and a signed up/down position counter. The counter keeps its sign in a separate bit beside the magnitude. A host selects the block by pulling chip select low. It then shifts in an opcode, optionally an address or data, and either shifts further bytes in or collects bytes on the output line. One read command returns its data on both data lines at once, two bits per clock.

The pins are sampled by a fast internal clock through a synchroniser. All SPI pins are plain level signals with no handshake. Each data line has an output value and a separate output-enable, which the pad ring turns into a tri-state pin. An active-low reset clears the sequencer, the status register and the counter. It leaves the array untouched. An active-low write-protect input, together with a guard bit in the status register, locks status writes.

Top module: `spi_cntmem`

## Requirements
- R1: In SPI mode 0 and in mode 3, bits are taken from `io0_i` on the rising SCK edge and returned MSB first on `io1_o`, changing on the falling SCK edge. Opcode 0x02 writes data bytes and 0x03 reads them. Each command sends two address bytes, high byte first. Only the low 11 address bits are used and the rest are ignored.
- R2: Within one command, consecutive data bytes go to consecutive addresses, and address 0x7FF is followed by 0x000.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. A data write while the latch is clear leaves the array unchanged.
- R4: When chip select rises after a 0x02 or 0x01 command, the write-enable latch is cleared.
- R5: Opcode 0x05 returns the status byte. Bit 7 is the guard bit, bits 6:2 are general-purpose, bit 1 is the write-enable latch and bit 0 reads 0.
- R6: Opcode 0x01 stores bits 7:2 of its first data byte only when the latch is set and not both `wp_n` is low and the guard bit is 1.
- R7: Opcode 0x3B reads like 0x03, but each falling edge drives two bits: the higher one on `io1_o` and the next one on `io0_o`. Four clocks carry one byte.
- R8: `io0_oe` and `io1_oe` are low while chip select is high, once the synchroniser delay has passed. During single-lane reads only `io1_oe` is high. During 0x3B data both are high.
- R9: Opcode 0xA0 adds one to the counter and 0xA1 subtracts one. Opcode 0xA2 returns 6 bytes, MSB first: zeros above, the sign at bit MAG_W (bit 42 by default), and the magnitude below it. A 1 in the sign bit means negative.
- R10: An increment at +max (all magnitude bits 1) or a decrement at -max leaves the counter unchanged.
- R11: A decrement of zero gives sign 1 with magnitude 1, and an increment of -1 gives sign 0 with magnitude 0. The sign is never set with a zero magnitude.
- R12: Opcode 0xA4 takes 6 data bytes. Their low MAG_W+1 bits form a target in the counter's sign-magnitude format, and the bits above are ignored. After the sixth byte the counter takes one step toward the target (up if the target is greater, down if smaller), or stays put if they are equal.
- R13: While `rst_n` is low, the sequencer returns to idle and the status register, latch and counter clear. Array contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, several times faster than SCK |
| rst_n | input | 1 | Active-low reset of sequencer, status and counter |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low (mode 0) or high (mode 3) |
| wp_n | input | 1 | Active-low write protect for the status register |
| io0_i | input | 1 | Serial data in (lane 0) |
| io0_o | output | 1 | Lane 0 output value, used by dual-lane reads |
| io0_oe | output | 1 | Lane 0 output enable |
| io1_o | output | 1 | Serial data out (lane 1) |
| io1_oe | output | 1 | Lane 1 output enable |

## Verification
The array is tried with multi-byte bursts that cross the top address, with the unused high address bits set, and in both clock polarities. Together these separate wrap and masking faults from plain data faults. The same bytes are then read on two lanes, which exposes any swap of lane order or bit pairing. The counter is driven up through zero and down through zero, pushed into both saturation limits (the bench uses a narrow magnitude), and stepped by position targets above, below, equal to and with junk above the target field. Each of these separates a distinct arithmetic branch. Status writes are tried under all combinations of latch, guard bit and protect pin that matter.

// File: rtl/spic_pkg.sv
package spic_pkg;
  localparam logic [7:0] OP_SR_WR   = 8'h01;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_SR_RD   = 8'h05;
  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_DREAD   = 8'h3B;
  localparam logic [7:0] OP_INC     = 8'hA0;
  localparam logic [7:0] OP_DEC     = 8'hA1;
  localparam logic [7:0] OP_CNT_RD  = 8'hA2;
  localparam logic [7:0] OP_POS     = 8'hA4;

  typedef enum logic [3:0] {
    ST_OP, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_SRW, ST_SRR, ST_CNTR, ST_POS, ST_SKIP
  } cmd_st_t;
endpackage

// File: rtl/spic_link.sv
module spic_link #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       io0_i,
  input  logic       tx_on,
  input  logic       tx_dual,
  input  logic [7:0] tx_byte,
  output logic       cs_end,
  output logic       rx_vld,
  output logic [7:0] rx_byte,
  output logic       tx_take,
  output logic       io0_o,
  output logic       io0_oe,
  output logic       io1_o,
  output logic       io1_oe
);
  logic [SYNC_N-1:0] sck_q, cs_q, d0_q;
  logic sck_d, cs_d, sel, rise, fall;
  logic [2:0] in_cnt, out_cnt;
  logic [6:0] in_sh;
  logic [7:0] out_sh;

  // pin synchroniser and edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      d0_q  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_q <= {sck_q[SYNC_N-2:0], sck};
      cs_q  <= {cs_q[SYNC_N-2:0], cs_n};
      d0_q  <= {d0_q[SYNC_N-2:0], io0_i};
      sck_d <= sck_q[SYNC_N-1];
      cs_d  <= cs_q[SYNC_N-1];
    end
  end

  always_comb begin
    sel     = ~cs_q[SYNC_N-1];
    cs_end  = cs_q[SYNC_N-1] & ~cs_d;
    rise    = sel & sck_q[SYNC_N-1] & ~sck_d;
    fall    = sel & ~sck_q[SYNC_N-1] & sck_d;
    rx_vld  = rise & (in_cnt == 3'd7);
    rx_byte = {in_sh, d0_q[SYNC_N-1]};
    tx_take = fall & tx_on & (out_cnt == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sel) begin
      in_cnt  <= 3'd0;
      in_sh   <= 7'd0;
      out_cnt <= 3'd0;
      out_sh  <= 8'd0;
      io0_o   <= 1'b0;
      io1_o   <= 1'b0;
      io0_oe  <= 1'b0;
      io1_oe  <= 1'b0;
    end else begin
      if (rise) begin
        in_sh  <= {in_sh[5:0], d0_q[SYNC_N-1]};
        in_cnt <= in_cnt + 3'd1;
      end
      if (fall && tx_on) begin
        io1_oe <= 1'b1;
        io0_oe <= tx_dual;
        if (out_cnt == 3'd0) begin
          io1_o   <= tx_byte[7];
          io0_o   <= tx_dual ? tx_byte[6] : 1'b0;
          out_sh  <= tx_dual ? {tx_byte[5:0], 2'b00} : {tx_byte[6:0], 1'b0};
          out_cnt <= tx_dual ? 3'd3 : 3'd7;
        end else begin
          io1_o   <= out_sh[7];
          io0_o   <= tx_dual ? out_sh[6] : 1'b0;
          out_sh  <= tx_dual ? {out_sh[5:0], 2'b00} : {out_sh[6:0], 1'b0};
          out_cnt <= out_cnt - 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spic_store.sv
module spic_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  // contents deliberately survive reset
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/spic_posctr.sv
module spic_posctr #(
  parameter int MAG_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             step,
  input  logic [MAG_W:0]   tgt,
  output logic             sign,
  output logic [MAG_W-1:0] mag
);
  localparam logic [MAG_W-1:0] MAX = '1;
  logic signed [MAG_W+1:0] cur_v, tgt_v;
  logic up, dn;

  always_comb begin
    cur_v = sign ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
    tgt_v = tgt[MAG_W] ? -$signed({2'b00, tgt[MAG_W-1:0]})
                       : $signed({2'b00, tgt[MAG_W-1:0]});
    up = inc || (step && (tgt_v > cur_v));
    dn = dec || (step && (tgt_v < cur_v));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign <= 1'b0;
      mag  <= '0;
    end else if (up) begin
      if (!sign) begin
        if (mag != MAX) mag <= mag + 1'b1;
      end else if (mag == {{(MAG_W-1){1'b0}}, 1'b1}) begin
        sign <= 1'b0;
        mag  <= '0;
      end else begin
        mag <= mag - 1'b1;
      end
    end else if (dn) begin
      if (sign) begin
        if (mag != MAX) mag <= mag + 1'b1;
      end else if (mag == '0) begin
        sign <= 1'b1;
        mag  <= {{(MAG_W-1){1'b0}}, 1'b1};
      end else begin
        mag <= mag - 1'b1;
      end
    end
  end

  // R11
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sign |-> (mag != '0));
  // R10
  pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !sign && mag == MAX) |=> (!sign && mag == MAX));
  // R11
  zero_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !sign && mag == '0) |=> (sign && mag == {{(MAG_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/spi_cntmem.sv
module spi_cntmem
  import spic_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int MAG_W     = 42,
  parameter int CNT_BYTES = 6,
  parameter int SYNC_N    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic wp_n,
  input  logic io0_i,
  output logic io0_o,
  output logic io0_oe,
  output logic io1_o,
  output logic io1_oe
);
  localparam int CW = MAG_W + 1;
  localparam int PW = 8 * CNT_BYTES;
  localparam int IW = $clog2(CNT_BYTES + 1);

  logic cs_end, rx_vld, tx_take, tx_on, tx_dual;
  logic [7:0] rx_byte, tx_byte, mem_q, sr_q, cnt_q, cmd;
  cmd_st_t st;
  logic [ADDR_W-1:0] addr;
  logic wel, wr_seen, guard;
  logic [4:0] spare;
  logic [IW-1:0] idx;
  logic [CW-1:0] pos_sh, tgt;
  logic c_sign;
  logic [MAG_W-1:0] c_mag;
  logic [PW-1:0] cnt_word;
  logic ctr_inc, ctr_dec, ctr_step, mem_we, last_pos;

  spic_link #(.SYNC_N(SYNC_N)) u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io0_i(io0_i),
    .tx_on(tx_on), .tx_dual(tx_dual), .tx_byte(tx_byte),
    .cs_end(cs_end), .rx_vld(rx_vld), .rx_byte(rx_byte), .tx_take(tx_take),
    .io0_o(io0_o), .io0_oe(io0_oe), .io1_o(io1_o), .io1_oe(io1_oe)
  );

  spic_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .addr(addr), .wdata(rx_byte), .rdata(mem_q)
  );

  spic_posctr #(.MAG_W(MAG_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ctr_inc), .dec(ctr_dec), .step(ctr_step),
    .tgt(tgt), .sign(c_sign), .mag(c_mag)
  );

  always_comb begin
    sr_q     = {guard, spare, wel, 1'b0};
    cnt_word = PW'({c_sign, c_mag});
    cnt_q    = (int'(idx) < CNT_BYTES)
             ? 8'(cnt_word >> (8 * (CNT_BYTES - 1 - int'(idx)))) : 8'h00;
    tx_on    = (st == ST_RD) || (st == ST_SRR) || (st == ST_CNTR);
    tx_dual  = (st == ST_RD) && (cmd == OP_DREAD);
    case (st)
      ST_RD:   tx_byte = mem_q;
      ST_SRR:  tx_byte = sr_q;
      default: tx_byte = cnt_q;
    endcase
    mem_we   = (st == ST_WR) && rx_vld && wel;
    ctr_inc  = (st == ST_OP) && rx_vld && (rx_byte == OP_INC);
    ctr_dec  = (st == ST_OP) && rx_vld && (rx_byte == OP_DEC);
    last_pos = int'(idx) == CNT_BYTES - 1;
    ctr_step = (st == ST_POS) && rx_vld && last_pos;
    tgt      = CW'({pos_sh, rx_byte});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_OP;
      cmd     <= 8'h00;
      addr    <= '0;
      wel     <= 1'b0;
      wr_seen <= 1'b0;
      guard   <= 1'b0;
      spare   <= 5'd0;
      idx     <= '0;
      pos_sh  <= '0;
    end else if (cs_end) begin
      st  <= ST_OP;
      idx <= '0;
      if (wr_seen) begin
        wel     <= 1'b0;
        wr_seen <= 1'b0;
      end
    end else begin
      if (tx_take && st == ST_RD) addr <= addr + 1'b1;
      if (tx_take && st == ST_CNTR && int'(idx) < CNT_BYTES) idx <= idx + 1'b1;
      if (rx_vld) begin
        case (st)
          ST_OP: begin
            cmd <= rx_byte;
            case (rx_byte)
              OP_READ, OP_DREAD: st <= ST_AHI;
              OP_WRITE:   begin st <= ST_AHI; wr_seen <= 1'b1; end
              OP_WEL_SET: begin wel <= 1'b1; st <= ST_SKIP; end
              OP_WEL_CLR: begin wel <= 1'b0; st <= ST_SKIP; end
              OP_SR_RD:   st <= ST_SRR;
              OP_SR_WR:   begin st <= ST_SRW; wr_seen <= 1'b1; end
              OP_CNT_RD:  st <= ST_CNTR;
              OP_POS:     st <= ST_POS;
              default:    st <= ST_SKIP;
            endcase
          end
          ST_AHI: begin
            addr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
            st <= ST_ALO;
          end
          ST_ALO: begin
            addr[7:0] <= rx_byte;
            st <= (cmd == OP_WRITE) ? ST_WR : ST_RD;
          end
          ST_WR: addr <= addr + 1'b1;
          ST_SRW: begin
            if (wel && (wp_n || !guard)) begin
              guard <= rx_byte[7];
              spare <= rx_byte[6:2];
            end
            st <= ST_SKIP;
          end
          ST_POS: begin
            pos_sh <= tgt;
            idx    <= idx + 1'b1;
            if (last_pos) st <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && wr_seen) |=> !wel);
  // R6
  guard_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(guard) |-> ($past(wel) && ($past(wp_n) || !$past(guard))));
  // R2
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && tx_take && addr == {ADDR_W{1'b1}}) |=> (addr == '0));
endmodule

// File: tb/spi_cntmem_test.sv
module spi_cntmem_test;
  localparam int HALF = 6;
  localparam int MAGW = 5;
  localparam int CMAX = (1 << MAGW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, wp_n = 1'b1, io0_i = 1'b0;
  logic io0_o, io0_oe, io1_o, io1_oe;
  int checks = 0, fails = 0, ctr = 0;
  bit m3 = 1'b0, done = 1'b0, oe0_seen, oe1_seen;

  always #5 clk = ~clk;

  spi_cntmem #(.MAG_W(MAGW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .wp_n(wp_n), .io0_i(io0_i),
    .io0_o(io0_o), .io0_oe(io0_oe), .io1_o(io1_o), .io1_oe(io1_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] enc(input int v);
    if (v < 0) return 48'(1 << MAGW) | 48'(-v);
    return 48'(v);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r0, output logic r1);
    sck = 1'b0;
    io0_i = b;
    wait_clk(HALF);
    r0 = io0_o;
    r1 = io1_o;
    oe0_seen |= io0_oe;
    oe1_seen |= io1_oe;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    logic d0, d1;
    for (int i = 7; i >= 0; i--) begin
      xbit(b[i], d0, d1);
      r[i] = d1;
    end
  endtask

  task automatic xdual(output logic [7:0] r);
    logic d0, d1;
    for (int k = 0; k < 4; k++) begin
      xbit(1'b0, d0, d1);
      r[7-2*k] = d1;
      r[6-2*k] = d0;
    end
  endtask

  task automatic begin_cmd();
    sck = m3;
    wait_clk(1);
    cs_n = 1'b0;
    oe0_seen = 1'b0;
    oe1_seen = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_cmd();
    if (!m3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic op(input logic [7:0] o);
    logic [7:0] r;
    begin_cmd();
    xbyte(o, r);
    end_cmd();
  endtask

  task automatic inc_n(input int n);
    for (int i = 0; i < n; i++) begin
      op(8'hA0);
      if (ctr < CMAX) ctr++;
    end
  endtask

  task automatic dec_n(input int n);
    for (int i = 0; i < n; i++) begin
      op(8'hA1);
      if (ctr > -CMAX) ctr--;
    end
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic [31:0] d, input int n);
    logic [7:0] r;
    begin_cmd();
    xbyte(8'h02, r);
    xbyte(a[15:8], r);
    xbyte(a[7:0], r);
    for (int i = n - 1; i >= 0; i--) xbyte(d[8*i +: 8], r);
    end_cmd();
  endtask

  task automatic mem_rd(input logic [7:0] opc, input logic [15:0] a, input int n,
                        output logic [31:0] q);
    logic [7:0] r, b;
    begin_cmd();
    xbyte(opc, r);
    xbyte(a[15:8], r);
    xbyte(a[7:0], r);
    q = 32'd0;
    for (int i = 0; i < n; i++) begin
      if (opc == 8'h3B) xdual(b);
      else xbyte(8'h00, b);
      q = {q[23:0], b};
    end
    end_cmd();
  endtask

  task automatic sr_rd(output logic [7:0] q);
    logic [7:0] r;
    begin_cmd();
    xbyte(8'h05, r);
    xbyte(8'h00, q);
    end_cmd();
  endtask

  task automatic sr_wr(input logic [7:0] d);
    logic [7:0] r;
    begin_cmd();
    xbyte(8'h01, r);
    xbyte(d, r);
    end_cmd();
  endtask

  task automatic cnt_rd(output logic [47:0] q);
    logic [7:0] r, b;
    begin_cmd();
    xbyte(8'hA2, r);
    q = 48'd0;
    for (int i = 0; i < 6; i++) begin
      xbyte(8'h00, b);
      q = {q[39:0], b};
    end
    end_cmd();
  endtask

  task automatic pos_ld(input logic [47:0] t);
    logic [7:0] r;
    int tv;
    begin_cmd();
    xbyte(8'hA4, r);
    for (int i = 5; i >= 0; i--) xbyte(t[8*i +: 8], r);
    end_cmd();
    tv = t[MAGW] ? -int'(t[MAGW-1:0]) : int'(t[MAGW-1:0]);
    if (tv > ctr && ctr < CMAX) ctr++;
    else if (tv < ctr && ctr > -CMAX) ctr--;
  endtask

  task automatic t_reset_state();
    logic [7:0] s;
    logic [47:0] c;
    chk("R8 oe idle", {io0_oe, io1_oe}, 2'b00);
    sr_rd(s);
    chk("R13 status after reset", s, 8'h00);
    cnt_rd(c);
    chk("R13 counter after reset", c, 48'd0);
  endtask

  task automatic t_write_enable();
    logic [7:0] s;
    logic [31:0] q;
    op(8'h06);
    sr_rd(s);
    chk("R3 latch set", s, 8'h02);
    op(8'h04);
    sr_rd(s);
    chk("R3 latch cleared", s, 8'h00);
    op(8'h06);
    mem_wr(16'h0010, 32'h11, 1);
    sr_rd(s);
    chk("R4 latch drops after write", s, 8'h00);
    mem_wr(16'h0010, 32'h22, 1);
    mem_rd(8'h03, 16'h0010, 1, q);
    chk("R3 write without latch ignored", q, 32'h11);
  endtask

  task automatic t_burst_wrap();
    logic [31:0] q;
    op(8'h06);
    mem_wr(16'hFFFE, 32'hA1B2C3D4, 4);
    mem_rd(8'h03, 16'h07FE, 4, q);
    chk("R2 burst across top address", q, 32'hA1B2C3D4);
    chk("R8 lane0 quiet in single read", {oe0_seen, oe1_seen}, 2'b01);
    mem_rd(8'h03, 16'hF800, 2, q);
    chk("R1 high address bits ignored", q, 32'hC3D4);
  endtask

  task automatic t_dual_read();
    logic [31:0] q;
    mem_rd(8'h3B, 16'h07FE, 4, q);
    chk("R7 dual-lane data", q, 32'hA1B2C3D4);
    chk("R8 both lanes driven in dual read", {oe0_seen, oe1_seen}, 2'b11);
    chk("R8 lanes released after deselect", {io0_oe, io1_oe}, 2'b00);
  endtask

  task automatic t_mode3();
    logic [31:0] q;
    m3 = 1'b1;
    op(8'h06);
    mem_wr(16'h0123, 32'h5E96, 2);
    mem_rd(8'h03, 16'h0123, 2, q);
    chk("R1 mode 3 round trip", q, 32'h5E96);
    m3 = 1'b0;
    mem_rd(8'h03, 16'h0124, 1, q);
    chk("R1 mode 0 reads mode 3 data", q, 32'h96);
  endtask

  task automatic t_status();
    logic [7:0] s;
    op(8'h06);
    sr_wr(8'h84);
    sr_rd(s);
    chk("R5 status layout", s, 8'h84);
    wp_n = 1'b0;
    op(8'h06);
    sr_rd(s);
    chk("R5 latch bit visible", s, 8'h86);
    sr_wr(8'h00);
    sr_rd(s);
    chk("R6 write blocked by pin and guard", s, 8'h84);
    wp_n = 1'b1;
    op(8'h06);
    sr_wr(8'h00);
    sr_rd(s);
    chk("R6 write allowed with pin high", s, 8'h00);
    wp_n = 1'b0;
    op(8'h06);
    sr_wr(8'h7F);
    sr_rd(s);
    chk("R6 write allowed with guard clear", s, 8'h7C);
    wp_n = 1'b1;
    sr_wr(8'h00);
    sr_rd(s);
    chk("R6 write blocked without latch", s, 8'h7C);
  endtask

  task automatic t_counter();
    logic [47:0] c;
    inc_n(3);
    cnt_rd(c);
    chk("R9 increments", c, enc(3));
    dec_n(4);
    cnt_rd(c);
    chk("R11 decrement through zero", c, enc(-1));
    chk("R9 model agrees", ctr, -1);
    dec_n(1);
    cnt_rd(c);
    chk("R9 negative count", c, enc(-2));
    inc_n(2);
    cnt_rd(c);
    chk("R11 no negative zero", c, 48'd0);
  endtask

  task automatic t_saturate();
    logic [47:0] c;
    inc_n(CMAX + 2);
    cnt_rd(c);
    chk("R10 positive limit", c, enc(CMAX));
    dec_n(2 * CMAX + 2);
    cnt_rd(c);
    chk("R10 negative limit", c, enc(-CMAX));
    inc_n(CMAX);
    cnt_rd(c);
    chk("R10 back to zero", c, 48'd0);
  endtask

  task automatic t_position();
    logic [47:0] c;
    pos_ld(enc(10));
    cnt_rd(c);
    chk("R12 step up toward target", c, enc(1));
    pos_ld(enc(-3));
    pos_ld(enc(-3));
    cnt_rd(c);
    chk("R12 step down toward target", c, enc(-1));
    pos_ld(enc(-1));
    cnt_rd(c);
    chk("R12 equal target holds", c, enc(-1));
    pos_ld(48'hFFFF_FFFF_FF00 | 48'h0A);
    cnt_rd(c);
    chk("R12 bits above target ignored", c, 48'd0);
  endtask

  task automatic t_reset_keep();
    logic [7:0] s;
    logic [47:0] c;
    logic [31:0] q;
    op(8'h06);
    sr_wr(8'h84);
    inc_n(2);
    wait_clk(2);
    rst_n = 1'b0;
    ctr = 0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    sr_rd(s);
    chk("R13 status cleared", s, 8'h00);
    cnt_rd(c);
    chk("R13 counter cleared", c, 48'd0);
    mem_rd(8'h03, 16'h0010, 1, q);
    chk("R13 array kept", q, 32'h11);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset_state();
    t_write_enable();
    t_burst_wrap();
    t_dual_read();
    t_mode3();
    t_status();
    t_counter();
    t_saturate();
    t_position();
    t_reset_keep();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule